// File: doc/BRIEF.md
# Register Write-Protection Gate

This block sits between a peripheral bus and the register file it guards. It owns two 32-bit key registers mapped into the same address space. A write to a guarded register is allowed through only while both keys hold their unlock words. Otherwise the write is dropped without any error response. Reads are never touched by the gate. The gate reports key contents on reads that hit a key offset and leaves every other read to the register file.

Software opens the gate by writing the first unlock word to key 0 and then the second unlock word to key 1. It closes the gate by writing zero, or any other non-matching value, to a key. A strict-order option makes key 1 accept its word only once key 0 already matches. In that mode every write to key 0 also wipes key 1, so the two-step sequence must always be repeated in full. Offsets at or above a configurable boundary are outside the guarded window and always pass.

Top module: `wp_gate`

## Requirements
- R1: After reset the gate is locked (`unlocked`=0) and both keys read back as 0x00000000.
- R2: Writing 0x83E70B13 to offset 0x6C and then 0x95A4F1E0 to offset 0x70 sets `unlocked` from the clock edge that completes the second write. From then on, a write to a guarded offset raises `reg_we` in the same cycle as the write.
- R3: While locked, a write to a guarded offset (below 0x9C and not a key offset) leaves `reg_we` low, so the register file keeps its old value.
- R4: Writing any value other than its unlock word to either key locks the gate from the next edge. Writing 0 to both keys leaves both reading 0 and the gate locked.
- R5: With strict order on (the default), a key 1 write made while key 0 does not hold its unlock word is ignored, and key 1 keeps its value. Every key 0 write clears key 1 to 0.
- R6: A write to a key offset never raises `reg_we`.
- R7: A write to an offset at or above 0x9C raises `reg_we` whether the gate is locked or not.
- R8: A read at a key offset raises `key_rsel` and returns the stored key on `key_rdata` in the same cycle. A read elsewhere leaves `key_rsel` low.
- R9: Key 0 holding its unlock word while key 1 does not leaves the gate locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_rd | input | 1 | Read strobe for the current bus cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| reg_we | output | 1 | Qualified write enable toward the register file |
| key_rsel | output | 1 | Read hits a key register; use `key_rdata` |
| key_rdata | output | 32 | Stored value of the addressed key |
| unlocked | output | 1 | Gate open for guarded writes |

## Verification
A corrupted key register or match flag appears within one cycle in two places. The `unlocked` output goes wrong, and a readback of that key returns the wrong value. A guarded write then either reaches the register file when it should have been dropped, or is dropped when it should have landed. The bench sees this in the same cycle on `reg_we`, and one cycle later in the model memory. A wrong region decode shows up immediately. It either raises `reg_we` on a key write or blocks a write to an offset outside the guarded window.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // Address classes seen by the gate; key offsets take priority over the window.
  typedef enum logic [1:0] {
    RGN_OPEN = 2'd0,
    RGN_PROT = 2'd1,
    RGN_KEY0 = 2'd2,
    RGN_KEY1 = 2'd3
  } wp_region_e;
endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned KEY0_OFF = 'h6C,
  parameter int unsigned KEY1_OFF = 'h70,
  parameter int unsigned PROT_END = 'h9C
) (
  input  logic [ADDR_W-1:0] addr,
  output wp_region_e        region
);
  localparam logic [ADDR_W-1:0] K0 = ADDR_W'(KEY0_OFF);
  localparam logic [ADDR_W-1:0] K1 = ADDR_W'(KEY1_OFF);
  localparam logic [ADDR_W-1:0] PE = ADDR_W'(PROT_END);

  always_comb begin
    if (addr == K0)      region = RGN_KEY0;
    else if (addr == K1) region = RGN_KEY1;
    else if (addr < PE)  region = RGN_PROT;
    else                 region = RGN_OPEN;
  end
endmodule

// File: rtl/wp_key_slot.sv
module wp_key_slot #(
  parameter int unsigned      DATA_W = 32,
  parameter logic [DATA_W-1:0] MAGIC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              match
);
  logic [DATA_W-1:0] value_q, value_d;
  logic              match_q, match_d;
  logic              en;

  // Clear wins over load; the match flag is precomputed from the next value.
  always_comb begin
    en      = load | clear;
    value_d = clear ? '0 : wdata;
    match_d = (value_d == MAGIC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      match_q <= 1'b0;
    end else if (en) begin
      value_q <= value_d;
      match_q <= match_d;
    end
  end

  assign value = value_q;
  assign match = match_q;
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_pkg::*;
#(
  parameter int unsigned       ADDR_W       = 8,
  parameter int unsigned       DATA_W       = 32,
  parameter int unsigned       KEY0_OFF     = 'h6C,
  parameter int unsigned       KEY1_OFF     = 'h70,
  parameter int unsigned       PROT_END     = 'h9C,
  parameter logic [DATA_W-1:0] KEY0_MAGIC   = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC   = 32'h95A4F1E0,
  parameter bit                STRICT_ORDER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              reg_we,
  output logic              key_rsel,
  output logic [DATA_W-1:0] key_rdata,
  output logic              unlocked
);
  localparam int unsigned NKEYS = 2;

  logic       rst_core_n;
  wp_region_e region;

  logic [NKEYS-1:0]             key_load;
  logic [NKEYS-1:0]             key_clear;
  logic [NKEYS-1:0]             key_match;
  logic [NKEYS-1:0][DATA_W-1:0] key_value;
  logic                         wr_k0, wr_k1;

  wp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  wp_addr_decode #(
    .ADDR_W   (ADDR_W),
    .KEY0_OFF (KEY0_OFF),
    .KEY1_OFF (KEY1_OFF),
    .PROT_END (PROT_END)
  ) u_dec (
    .addr   (bus_addr),
    .region (region)
  );

  assign wr_k0 = bus_wr && (region == RGN_KEY0);
  assign wr_k1 = bus_wr && (region == RGN_KEY1);

  // Sequencing rule for the second key.
  generate
    if (STRICT_ORDER) begin : g_strict
      always_comb begin
        key_load[0]  = wr_k0;
        key_clear[0] = 1'b0;
        key_load[1]  = wr_k1 && key_match[0];
        key_clear[1] = wr_k0;
      end
    end else begin : g_free
      always_comb begin
        key_load[0]  = wr_k0;
        key_clear[0] = 1'b0;
        key_load[1]  = wr_k1;
        key_clear[1] = 1'b0;
      end
    end
  endgenerate

  generate
    for (genvar k = 0; k < NKEYS; k++) begin : g_key
      wp_key_slot #(
        .DATA_W (DATA_W),
        .MAGIC  ((k == 0) ? KEY0_MAGIC : KEY1_MAGIC)
      ) u_slot (
        .clk   (clk),
        .rst_n (rst_core_n),
        .load  (key_load[k]),
        .clear (key_clear[k]),
        .wdata (bus_wdata),
        .value (key_value[k]),
        .match (key_match[k])
      );
    end
  endgenerate

  assign unlocked = &key_match;

  always_comb begin
    reg_we = 1'b0;
    if (bus_wr && rst_core_n) begin
      case (region)
        RGN_OPEN: reg_we = 1'b1;
        RGN_PROT: reg_we = unlocked;
        default:  reg_we = 1'b0;
      endcase
    end
  end

  always_comb begin
    key_rsel  = bus_rd && ((region == RGN_KEY0) || (region == RGN_KEY1));
    key_rdata = '0;
    if (region == RGN_KEY0)      key_rdata = key_value[0];
    else if (region == RGN_KEY1) key_rdata = key_value[1];
  end
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       KEY0_OFF   = 'h6C,
  parameter int unsigned       KEY1_OFF   = 'h70,
  parameter int unsigned       PROT_END   = 'h9C,
  parameter logic [DATA_W-1:0] KEY0_MAGIC = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_MAGIC = 32'h95A4F1E0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              reg_we,
  input logic              key_rsel,
  input logic              unlocked
);
  logic at_k0, at_k1, at_prot, at_open;
  assign at_k0   = (bus_addr == ADDR_W'(KEY0_OFF));
  assign at_k1   = (bus_addr == ADDR_W'(KEY1_OFF));
  assign at_prot = !at_k0 && !at_k1 && (bus_addr < ADDR_W'(PROT_END));
  assign at_open = !at_k0 && !at_k1 && !(bus_addr < ADDR_W'(PROT_END));

  a_r3_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_prot && !unlocked) |-> !reg_we);

  a_r2_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_prot && unlocked) |-> reg_we);

  a_r6_key_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (at_k0 || at_k1)) |-> !reg_we);

  a_r7_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_open) |-> reg_we);

  a_r4_bad_key0_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_k0 && bus_wdata != KEY0_MAGIC) |=> !unlocked);

  a_r4_bad_key1_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_k1 && bus_wdata != KEY1_MAGIC) |=> !unlocked);

  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && ((at_k0 && bus_wdata == KEY0_MAGIC) ||
                                         (at_k1 && bus_wdata == KEY1_MAGIC))));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !(bus_wr && (at_k0 || at_k1))) |=> unlocked);

  a_r8_key_read: assert property (@(posedge clk) disable iff (!rst_n)
    key_rsel |-> (bus_rd && (at_k0 || at_k1)));
endmodule

bind wp_gate wp_gate_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .KEY0_OFF   (KEY0_OFF),
  .KEY1_OFF   (KEY1_OFF),
  .PROT_END   (PROT_END),
  .KEY0_MAGIC (KEY0_MAGIC),
  .KEY1_MAGIC (KEY1_MAGIC)
) u_wp_gate_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .reg_we    (reg_we),
  .key_rsel  (key_rsel),
  .unlocked  (unlocked)
);

// File: tb/test_wp_gate.sv
`timescale 1ns/1ps
module test_wp_gate;
  localparam logic [7:0]  K0 = 8'h6C;
  localparam logic [7:0]  K1 = 8'h70;
  localparam logic [31:0] M0 = 32'h83E70B13;
  localparam logic [31:0] M1 = 32'h95A4F1E0;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        reg_we;
  logic        key_rsel;
  logic [31:0] key_rdata;
  logic        unlocked;

  int n_chk;
  int n_err;
  bit done;
  logic [31:0] mem [64];

  wp_gate i_wp_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .reg_we    (reg_we),
    .key_rsel  (key_rsel),
    .key_rdata (key_rdata),
    .unlocked  (unlocked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Register file stand-in, written only through the qualifier.
  always @(posedge clk) begin
    if (reg_we) mem[bus_addr[7:2]] <= bus_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output logic we);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1 we = reg_we;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic sel, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 sel = key_rsel; d = key_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic s; logic [31:0] d; logic we;
    check("R1 unlocked after reset", {31'b0, unlocked}, 32'd0);
    bus_read(K0, s, d);
    check("R1 key0 reset value", d, 32'd0);
    check("R8 key0 read select", {31'b0, s}, 32'd1);
    bus_read(K1, s, d);
    check("R1 key1 reset value", d, 32'd0);
    bus_write(8'h00, 32'hDEAD0001, we);
    check("R3 locked write qualifier", {31'b0, we}, 32'd0);
    #1 check("R3 locked write dropped", mem[0], 32'd0);
  endtask

  task automatic t_half_unlock;
    logic s; logic [31:0] d; logic we;
    bus_write(K0, M0, we);
    check("R6 key0 write qualifier", {31'b0, we}, 32'd0);
    check("R9 key0 alone stays locked", {31'b0, unlocked}, 32'd0);
    bus_read(K0, s, d);
    check("R8 key0 readback", d, M0);
    bus_write(8'h04, 32'h11112222, we);
    check("R9 guarded write still dropped", {31'b0, we}, 32'd0);
  endtask

  task automatic t_unlock;
    logic we;
    bus_write(K1, M1, we);
    check("R6 key1 write qualifier", {31'b0, we}, 32'd0);
    check("R2 unlocked after key1", {31'b0, unlocked}, 32'd1);
    bus_write(8'h04, 32'hCAFE0004, we);
    check("R2 guarded write qualifier", {31'b0, we}, 32'd1);
    #1 check("R2 guarded write landed", mem[1], 32'hCAFE0004);
  endtask

  task automatic t_relock;
    logic s; logic [31:0] d; logic we;
    bus_write(K1, 32'h00001234, we);
    check("R4 wrong key1 locks", {31'b0, unlocked}, 32'd0);
    bus_write(8'h08, 32'hBAD00008, we);
    check("R4 write after relock dropped", {31'b0, we}, 32'd0);
    #1 check("R4 memory unchanged", mem[2], 32'd0);
    bus_write(K0, 32'd0, we);
    bus_write(K1, 32'd0, we);
    bus_read(K0, s, d);
    check("R4 key0 zeroed", d, 32'd0);
    bus_read(K1, s, d);
    check("R4 key1 zeroed", d, 32'd0);
    check("R4 locked after zeroing", {31'b0, unlocked}, 32'd0);
  endtask

  task automatic t_strict_order;
    logic s; logic [31:0] d; logic we;
    bus_write(K1, M1, we);
    bus_read(K1, s, d);
    check("R5 early key1 ignored", d, 32'd0);
    bus_write(K0, M0, we);
    check("R5 reversed order stays locked", {31'b0, unlocked}, 32'd0);
    bus_write(K1, M1, we);
    check("R5 in-order unlock", {31'b0, unlocked}, 32'd1);
    bus_write(K0, M0, we);
    bus_read(K1, s, d);
    check("R5 key0 write clears key1", d, 32'd0);
    check("R5 locked after key0 rewrite", {31'b0, unlocked}, 32'd0);
  endtask

  task automatic t_window;
    logic s; logic [31:0] d; logic we;
    bus_write(8'hA0, 32'h0FEE00A0, we);
    check("R7 outside window while locked", {31'b0, we}, 32'd1);
    #1 check("R7 outside write landed", mem[40], 32'h0FEE00A0);
    bus_write(8'h9C, 32'h0000009C, we);
    check("R7 window boundary offset", {31'b0, we}, 32'd1);
    bus_write(8'h98, 32'h00000098, we);
    check("R3 last guarded offset", {31'b0, we}, 32'd0);
    bus_read(8'h10, s, d);
    check("R8 non-key read select", {31'b0, s}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    n_chk = 0; n_err = 0; done = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_half_unlock();
    t_unlock();
    t_relock();
    t_strict_order();
    t_window();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule